// File: doc/BRIEF.md
# Multiprocessor UART Transmitter

This block is the transmit half of an asynchronous serial port. Software writes a character into a single-entry holding buffer. On the next baud tick the character moves into a shift register, which drives it onto the serial line one bit per baud tick. The baud tick comes from outside the block, so the block has no baud generator of its own. The character format is set by a group of configuration inputs: 7 or 8 data bits, LSB-first or MSB-first order, optional odd or even parity, and one or two stop bits.

Several stations can share one serial line, so the block can tag a character as an address in two ways:
- In idle-gap mode, the address character is preceded by an exactly timed high period.
- In address-bit mode, the frame carries one extra bit that marks it as an address.

The block can also send a break frame with every bit low. In the header mode used by bus-synchronised links, it sends a long low break, then a high delimiter of programmable length, and then the 0x55 synch character. The address request and the break request are set by pulses on their set inputs. The block clears each request itself when the start bit of the frame that used it goes out.

Top module: `mp_uart_tx`

## Requirements
- R1: After reset the line is high, buf_empty is 1, busy is 0, and both request outputs are 0.
- R2: In plain mode (mode code 0) a frame is sent as follows. Bits change only on baud ticks. The start bit is low, then the 8 data bits go out LSB first, then one high stop bit. After the frame the line returns high.
- R3: When msb_first is 1, data bits go out highest first. When seven_bit is 1, only data bits 6..0 are sent and bit 7 of the written value has no effect on the line.
- R4: When par_en is 1, a parity bit follows the data. With par_even set to 1, the parity bit makes the count of ones even; with par_even set to 0, it makes the count odd. When two_stop is 1, two high stop bits are sent.
- R5: In address-bit mode (mode code 2), an address bit follows the parity position. Its value is the address request as it stood when the buffer moved into the shift register. When parity is on, the address bit is included in the parity sum.
- R6: In idle-gap mode (mode code 1), a frame sent with the address request set is preceded by exactly 11 high bit times. Without the request, the start bit follows at once.
- R7: In modes 0 to 2, a frame sent with the break request set is low for every bit position of the frame, including parity, address and stop bits.
- R8: In header mode (mode code 3), a frame sent with the break request set is sent as 13 low bits, then (delim+1) high bits, then the written character framed normally.
- R9: The address and break requests clear on the tick at which the start bit of the frame that captured them is driven. Until then they stay set.
- R10: A buffer write clears buf_empty. buf_empty sets again on the baud tick that moves the buffer into the shift register.
- R11: busy is 1 from a buffer write until the tick that ends the last stop bit.
- R12: A character written while a frame is on the line starts on the tick that ends the current stop bit, with no idle bit between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mode | input | 2 | 0 plain, 1 idle-gap address, 2 address bit, 3 break/synch header |
| cfg_msb_first | input | 1 | Send data MSB first |
| cfg_seven_bit | input | 1 | 7 data bits instead of 8 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 even, 0 odd parity |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_delim | input | DELIM_W | Header delimiter length minus one |
| addr_req_set | input | 1 | Pulse to set the address request |
| brk_req_set | input | 1 | Pulse to set the break request |
| addr_req | output | 1 | Address request pending |
| brk_req | output | 1 | Break request pending |
| wr_en | input | 1 | Holding buffer write strobe |
| wr_data | input | DATA_W | Character to send |
| buf_empty | output | 1 | Holding buffer free |
| baud_tick | input | 1 | One pulse per bit time |
| tx | output | 1 | Serial line, idle high |
| busy | output | 1 | Character pending or on the line |

## Verification
The bench builds the block with its default parameters:
- DATA_W = 8
- 11-bit idle gap
- 13-bit break
- 2-bit delimiter field
- header support enabled

With these values, every header and address variant is reachable, including the longest frame of 29 bit times (break, 4-bit delimiter, synch character, stop). A baud tick every fourth clock puts writes, loads and shifts on distinct edges, so the point where a request clears and the point where buf_empty sets can be observed between ticks.

// File: rtl/mpt_pkg.sv
package mpt_pkg;

   typedef enum logic [1:0] {
      MODE_PLAIN = 2'd0,
      MODE_IDLE  = 2'd1,
      MODE_ABIT  = 2'd2,
      MODE_ABAUD = 2'd3
   } txmode_e;

   typedef struct packed {
      txmode_e mode;
      logic    msb_first;
      logic    seven_bit;
      logic    par_en;
      logic    par_even;
      logic    two_stop;
   } txcfg_t;

endpackage

// File: rtl/mpt_holdbuf.sv
module mpt_holdbuf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   input  logic              start_pulse,
   input  logic              addr_set,
   input  logic              brk_set,
   output logic [DATA_W-1:0] data_q,
   output logic              empty_q,
   output logic              addr_req_q,
   output logic              brk_req_q
);
   logic used_addr, used_brk;
   logic clr_addr, clr_brk;

   // a request is consumed only by the frame that captured it
   assign clr_addr = start_pulse && (take ? addr_req_q : used_addr);
   assign clr_brk  = start_pulse && (take ? brk_req_q  : used_brk);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q     <= '0;
         empty_q    <= 1'b1;
         addr_req_q <= 1'b0;
         brk_req_q  <= 1'b0;
         used_addr  <= 1'b0;
         used_brk   <= 1'b0;
      end else begin
         if (wr_en) begin
            data_q  <= wr_data;
            empty_q <= 1'b0;
         end else if (take) begin
            empty_q <= 1'b1;
         end
         if (take) begin
            used_addr <= addr_req_q;
            used_brk  <= brk_req_q;
         end
         addr_req_q <= addr_set | (addr_req_q & ~clr_addr);
         brk_req_q  <= brk_set  | (brk_req_q  & ~clr_brk);
      end
   end

   assert_write_fills_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !empty_q);
   assert_load_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
      take && !wr_en |=> empty_q);
   assert_addr_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_addr && !addr_set |=> !addr_req_q);
   assert_brk_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_brk && !brk_set |=> !brk_req_q);

endmodule

// File: rtl/mpt_framer.sv
module mpt_framer
   import mpt_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int IDLE_BITS = 11,
   parameter int BRK_BITS  = 13,
   parameter int DELIM_W   = 2,
   parameter bit HDR_EN    = 1'b1,
   parameter int FW        = 29,
   parameter int CW        = 5
) (
   input  txcfg_t             cfg,
   input  logic [DELIM_W-1:0] delim,
   input  logic [DATA_W-1:0]  data,
   input  logic               addr,
   input  logic               brk,
   output logic [FW-1:0]      frm,
   output logic [FW-1:0]      mrk,
   output logic [CW-1:0]      len
);
   localparam logic [FW-1:0] BRK_MASK = FW'((64'd1 << BRK_BITS) - 64'd1);

   logic [DATA_W-1:0] rev_full, rev_short, dmask, dword, ord;
   logic [CW-1:0]     nbits, p;
   logic              hdr_on, gap_on, abit, brk_flat, par_x;

   // reversed data for MSB-first order, one variant per character length
   for (genvar g = 0; g < DATA_W; g++) begin : g_rev
      assign rev_full[g] = data[DATA_W-1-g];
      if (g < DATA_W-1) begin : g_s
         assign rev_short[g] = data[DATA_W-2-g];
      end else begin : g_top
         assign rev_short[g] = 1'b0;
      end
   end

   if (HDR_EN) begin : g_hdr
      assign hdr_on = (cfg.mode == MODE_ABAUD) && brk;
   end else begin : g_nohdr
      assign hdr_on = 1'b0;
   end

   assign gap_on   = (cfg.mode == MODE_IDLE) && addr;
   assign abit     = (cfg.mode == MODE_ABIT);
   assign brk_flat = brk && !hdr_on;
   assign dmask    = cfg.seven_bit ? {1'b0, {(DATA_W-1){1'b1}}} : {DATA_W{1'b1}};
   assign dword    = data & dmask;
   assign nbits    = cfg.seven_bit ? CW'(DATA_W-1) : CW'(DATA_W);
   assign ord      = cfg.msb_first ? (cfg.seven_bit ? rev_short : rev_full) : dword;
   assign par_x    = (^dword) ^ (abit & addr);

   always_comb begin
      frm = '1;
      mrk = '0;
      p   = '0;
      if (gap_on) p = CW'(IDLE_BITS);
      if (hdr_on) begin
         frm = frm & ~BRK_MASK;
         p   = CW'(BRK_BITS) + CW'(delim) + CW'(1);
      end
      frm[p] = 1'b0;
      mrk[p] = 1'b1;
      p      = p + CW'(1);
      frm    = (frm & ~(FW'(dmask) << p)) | (FW'(ord) << p);
      p      = p + nbits;
      if (cfg.par_en) begin
         frm[p] = cfg.par_even ? par_x : ~par_x;
         p      = p + CW'(1);
      end
      if (abit) begin
         frm[p] = addr;
         p      = p + CW'(1);
      end
      p = p + (cfg.two_stop ? CW'(2) : CW'(1));
      if (brk_flat) frm = frm & ({FW{1'b1}} << p);
      len = p;
   end

endmodule

// File: rtl/mpt_shifter.sv
module mpt_shifter #(
   parameter int FW = 29,
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          baud_tick,
   input  logic          pending,
   input  logic [FW-1:0] frm_in,
   input  logic [FW-1:0] mrk_in,
   input  logic [CW-1:0] len_in,
   output logic          take,
   output logic          start_pulse,
   output logic          act,
   output logic          tx_q
);
   logic [FW-1:0] sh, mk;
   logic [CW-1:0] cnt;
   logic          more, seen;

   assign more        = act && (cnt > CW'(1));
   assign take        = baud_tick && pending && !more;
   assign start_pulse = baud_tick && ((more && mk[1]) || (take && mrk_in[0]));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '1;
         mk   <= '0;
         cnt  <= '0;
         act  <= 1'b0;
         tx_q <= 1'b1;
         seen <= 1'b0;
      end else begin
         seen <= 1'b1;
         if (baud_tick) begin
            if (more) begin
               sh   <= sh >> 1;
               mk   <= mk >> 1;
               cnt  <= cnt - CW'(1);
               tx_q <= sh[1];
            end else if (pending) begin
               sh   <= frm_in;
               mk   <= mrk_in;
               cnt  <= len_in;
               act  <= 1'b1;
               tx_q <= frm_in[0];
            end else begin
               act  <= 1'b0;
               tx_q <= 1'b1;
            end
         end
      end
   end

   assert_tx_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !baud_tick |=> $stable(tx_q));
   assert_load_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
      seen && $rose(act) |-> $past(baud_tick));
   assert_idle_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !act |-> tx_q);

endmodule

// File: rtl/mp_uart_tx.sv
module mp_uart_tx
   import mpt_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int IDLE_BITS = 11,
   parameter int BRK_BITS  = 13,
   parameter int DELIM_W   = 2,
   parameter bit HDR_EN    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         cfg_mode,
   input  logic               cfg_msb_first,
   input  logic               cfg_seven_bit,
   input  logic               cfg_par_en,
   input  logic               cfg_par_even,
   input  logic               cfg_two_stop,
   input  logic [DELIM_W-1:0] cfg_delim,
   input  logic               addr_req_set,
   input  logic               brk_req_set,
   output logic               addr_req,
   output logic               brk_req,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_data,
   output logic               buf_empty,
   input  logic               baud_tick,
   output logic               tx,
   output logic               busy
);
   localparam int HDR_MAX = HDR_EN ? (BRK_BITS + (1 << DELIM_W)) : 0;
   localparam int PRE_MAX = (HDR_MAX > IDLE_BITS) ? HDR_MAX : IDLE_BITS;
   localparam int FW      = PRE_MAX + 1 + DATA_W + 1 + 1 + 2;
   localparam int CW      = $clog2(FW + 1);

   if (DATA_W < 5 || DATA_W > 16) begin : g_chk_data
      $error("DATA_W must lie in 5..16");
   end
   if (IDLE_BITS < 1 || BRK_BITS < 1 || DELIM_W < 1) begin : g_chk_len
      $error("gap, break and delimiter widths must be positive");
   end

   txcfg_t            cfg;
   logic [DATA_W-1:0] hold_data;
   logic [FW-1:0]     frm, mrk;
   logic [CW-1:0]     len;
   logic              take, start_pulse, act;

   assign cfg = '{mode: txmode_e'(cfg_mode), msb_first: cfg_msb_first,
                  seven_bit: cfg_seven_bit, par_en: cfg_par_en,
                  par_even: cfg_par_even, two_stop: cfg_two_stop};

   mpt_holdbuf #(.DATA_W(DATA_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .take(take), .start_pulse(start_pulse),
      .addr_set(addr_req_set), .brk_set(brk_req_set),
      .data_q(hold_data), .empty_q(buf_empty),
      .addr_req_q(addr_req), .brk_req_q(brk_req));

   mpt_framer #(.DATA_W(DATA_W), .IDLE_BITS(IDLE_BITS), .BRK_BITS(BRK_BITS),
                .DELIM_W(DELIM_W), .HDR_EN(HDR_EN), .FW(FW), .CW(CW)) u_frm (
      .cfg(cfg), .delim(cfg_delim), .data(hold_data),
      .addr(addr_req), .brk(brk_req), .frm(frm), .mrk(mrk), .len(len));

   mpt_shifter #(.FW(FW), .CW(CW)) u_sh (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .pending(!buf_empty),
      .frm_in(frm), .mrk_in(mrk), .len_in(len),
      .take(take), .start_pulse(start_pulse), .act(act), .tx_q(tx));

   assign busy = act | !buf_empty;

   assert_quiet_line_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> tx);
   assert_write_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> busy);

endmodule

// File: tb/sim_mp_uart_tx.sv
`timescale 1ns/1ps
module sim_mp_uart_tx;

   typedef struct packed {
      logic [1:0] mode;
      logic       msb, seven, pe, pev, two;
      logic [1:0] delim;
      logic       addr, brk;
      logic [7:0] data;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 8'hA5},
      '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 8'h3C},
      '{2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 8'hDA},
      '{2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 8'h71},
      '{2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 8'h0F},
      '{2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 8'h12},
      '{2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 8'h12},
      '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 8'h81},
      '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 8'h81},
      '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 8'h00},
      '{2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 8'h00},
      '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 8'h55},
      '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 1'b1, 8'h55},
      '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 8'h55}
   };

   logic       clk = 1'b0, rst_n = 1'b0;
   logic [1:0] cfg_mode = '0, cfg_delim = '0;
   logic       cfg_msb_first = 0, cfg_seven_bit = 0, cfg_par_en = 0;
   logic       cfg_par_even = 0, cfg_two_stop = 0;
   logic       addr_req_set = 0, brk_req_set = 0, wr_en = 0, baud_tick = 0;
   logic [7:0] wr_data = '0;
   logic       addr_req, brk_req, buf_empty, tx, busy;

   int n_chk = 0, n_fail = 0, tick_ctr = 0;
   bit exp_q[$];
   bit cap_q[$];

   mp_uart_tx u0 (.*);

   always #5 clk = ~clk;

   always @(negedge clk) begin
      tick_ctr  <= (tick_ctr + 1) % 4;
      baud_tick <= (tick_ctr == 2);
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act_v, input int exp_v);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic get_bits(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         while (!baud_tick) @(posedge clk);
         @(negedge clk);
         cap_q.push_back(tx);
      end
   endtask

   task automatic write(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic request(input bit a, input bit b);
      @(negedge clk);
      addr_req_set = a; brk_req_set = b;
      @(negedge clk);
      addr_req_set = 1'b0; brk_req_set = 1'b0;
   endtask

   task automatic build(input vec_t v);
      int n, ones;
      bit pb;
      n = v.seven ? 7 : 8;
      ones = 0;
      if (v.mode == 2'd1 && v.addr) repeat (11) exp_q.push_back(1'b1);
      if (v.mode == 2'd3 && v.brk) begin
         repeat (13) exp_q.push_back(1'b0);
         repeat (int'(v.delim) + 1) exp_q.push_back(1'b1);
      end
      exp_q.push_back(1'b0);
      for (int i = 0; i < n; i++) begin
         pb = v.msb ? v.data[n-1-i] : v.data[i];
         ones += pb;
         exp_q.push_back(pb);
      end
      if (v.mode == 2'd2) ones += v.addr;
      if (v.pe) exp_q.push_back(v.pev ? ones[0] : ~ones[0]);
      if (v.mode == 2'd2) exp_q.push_back(v.addr);
      exp_q.push_back(1'b1);
      if (v.two) exp_q.push_back(1'b1);
      if (v.brk && v.mode != 2'd3)
         for (int i = 0; i < exp_q.size(); i++) exp_q[i] = 1'b0;
   endtask

   function automatic string tag(input vec_t v);
      if (v.mode == 2'd3 && v.brk) return "R8";
      if (v.brk) return "R7";
      if (v.mode == 2'd1) return "R6";
      if (v.mode == 2'd2) return "R5";
      if (v.pe || v.two) return "R4";
      if (v.msb || v.seven) return "R3";
      return "R2";
   endfunction

   task automatic compare(input string req, input int k);
      int bad;
      bad = -1;
      for (int i = 0; i < exp_q.size(); i++)
         if (bad < 0 && cap_q[i] != exp_q[i]) bad = i;
      check(bad < 0, req, $sformatf("frame %0d bit %0d", k, bad),
            (bad < 0) ? 0 : int'(cap_q[bad]), (bad < 0) ? 0 : int'(exp_q[bad]));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(tx == 1'b1, "R1", "tx", tx, 1);
      check(buf_empty == 1'b1, "R1", "buf_empty", buf_empty, 1);
      check(busy == 1'b0, "R1", "busy", busy, 0);
      check(addr_req == 1'b0 && brk_req == 1'b0, "R1", "requests",
            {addr_req, brk_req}, 0);

      // table walk: R2..R8, with request clearing (R9) after each frame
      for (int k = 0; k < NV; k++) begin
         vec_t v;
         v = VEC[k];
         @(negedge clk);
         cfg_mode = v.mode; cfg_msb_first = v.msb; cfg_seven_bit = v.seven;
         cfg_par_en = v.pe; cfg_par_even = v.pev; cfg_two_stop = v.two;
         cfg_delim = v.delim;
         if (v.addr || v.brk) request(v.addr, v.brk);
         exp_q.delete(); cap_q.delete();
         build(v);
         exp_q.push_back(1'b1);
         write(v.data);
         get_bits(exp_q.size());
         compare(tag(v), k);
         check(addr_req == 1'b0 && brk_req == 1'b0, "R9", "requests after frame",
               {addr_req, brk_req}, 0);
      end

      // R10 / R11: buffer flag and busy around a load
      @(negedge clk);
      cfg_mode = 2'd0; cfg_msb_first = 0; cfg_seven_bit = 0;
      cfg_par_en = 0; cfg_two_stop = 0;
      write(8'h5A);
      check(buf_empty == 1'b0, "R10", "empty after write", buf_empty, 0);
      check(busy == 1'b1, "R11", "busy before load", busy, 1);
      cap_q.delete();
      get_bits(1);
      check(buf_empty == 1'b1, "R10", "empty after load", buf_empty, 1);
      get_bits(9);
      check(busy == 1'b1, "R11", "busy in stop bit", busy, 1);
      get_bits(1);
      check(busy == 1'b0, "R11", "busy after frame", busy, 0);

      // R9: address request survives the idle gap, clears at start bit
      @(negedge clk);
      cfg_mode = 2'd1;
      request(1'b1, 1'b0);
      write(8'h44);
      cap_q.delete();
      get_bits(5);
      check(addr_req == 1'b1, "R9", "request during gap", addr_req, 1);
      get_bits(7);
      check(cap_q[11] == 1'b0, "R9", "start bit position", cap_q[11], 0);
      check(addr_req == 1'b0, "R9", "request at start bit", addr_req, 0);
      get_bits(10);

      // R12: back-to-back frames with no idle bit between them
      @(negedge clk);
      cfg_mode = 2'd0;
      exp_q.delete(); cap_q.delete();
      build('{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 8'h11});
      build('{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 8'hE2});
      exp_q.push_back(1'b1);
      write(8'h11);
      get_bits(1);
      write(8'hE2);
      get_bits(exp_q.size() - 1);
      compare("R12", 99);
      check(busy == 1'b0, "R12", "idle after pair", busy, 0);

      report();
   end

endmodule